// File: doc/BRIEF.md
# Chained Command-List I/O Processor

This block is a channel-style I/O processor that moves data between a peripheral port and main memory without the host touching each transfer. The host points the block at a list of command blocks held in memory and pulses a start input. From then on the block works alone. It reads each command block from memory and decodes it. It then carries out the transfer that block describes and moves to the next block, until it meets an end marker or a malformed command. At that point it interrupts the host.

Each command block is four consecutive 32-bit words: an operation code, a device address, a memory data address and a word count. The block shares the memory bus with the host. It raises a request for every single word, whether that word is a command word or a data word, and proceeds only when granted. An external arbiter can therefore slip host accesses in between any two of its words. The device side is a simple strobed port: a read strobe samples the device data in the same cycle, and a write strobe presents the data to the device.

When a command is malformed, the block stops and keeps two pieces of status: an error flag, and the zero-based position of the failing command within the list. Both stay visible until the next accepted start.

Top module: `iop_cmd_proc`

## Requirements
- R1: After reset, busy, irq, err_valid, mem_req, dev_rd and dev_wr are all 0.
- R2: A start pulse while idle latches list_base. The block then reads the command words at list_base, +4, +8 and +12 in that order: opcode, device address, memory address, word count. The next command block is fetched 16 bytes further on.
- R3: Opcode 1 (device to memory) repeats once per counted word: one dev_rd strobe, with the device data sampled in that cycle, then a memory write of that word. The memory writes go to consecutive word addresses, starting at the memory address and stepping by 4.
- R4: Opcode 2 (memory to device) repeats once per counted word: one memory read from consecutive word addresses, starting at the memory address, then one dev_wr strobe carrying that word.
- R5: During every strobe, dev_addr carries the low DEV_AW bits of the device-address word. The count is the low CNT_W bits of the count word. A count of 0 performs no device or memory data cycle, and the next command block is fetched.
- R6: Opcode 0 ends the list. irq is high for exactly one cycle, busy is 0 in that same cycle, and err_valid stays 0.
- R7: Any opcode other than 0, 1 or 2 stops the list. irq pulses for one cycle, err_valid becomes 1, and err_index holds the zero-based position of that command block within the list.
- R8: While mem_req is high and mem_gnt is low, mem_req, mem_we, mem_addr and mem_wdata hold their values into the next cycle. A read takes mem_rdata in the grant cycle, and a write is committed in the grant cycle.
- R9: A start pulse while busy is ignored. While busy is 0, the block drives no memory request and no device strobe.
- R10: err_valid and err_index hold while the block is idle. An accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Host pulse that launches the list at list_base |
| list_base | input | 32 | Byte address of the first command block |
| busy | output | 1 | High while a list is being processed |
| irq | output | 1 | One-cycle completion interrupt |
| err_valid | output | 1 | Last list stopped on a malformed command |
| err_index | output | IDX_W | Position of the malformed command block |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory cycle granted this cycle |
| mem_rdata | input | 32 | Memory read data, valid in the grant cycle |
| dev_addr | output | DEV_AW | Target device address |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | 32 | Device write data |
| dev_rdata | input | 32 | Device read data, sampled during dev_rd |

## Verification
The assertions assume that the arbiter only raises mem_gnt while mem_req is high. They also assume word-aligned list and data addresses, so every request address is aligned. The bench forms the grant as the request gated by an allow bit, and it places every list and buffer on a 4-byte boundary. One run holds back the allow bit from a pseudo-random sequence, so requests stall for several cycles. During that run a second start arrives mid-list and points at a list that, if it were accepted, would end in an error.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int WORD_W         = 32;
    localparam int WORD_BYTES     = 4;
    localparam int DESC_WORDS     = 4;
    localparam int DESC_BYTES     = DESC_WORDS * WORD_BYTES;

    localparam logic [WORD_W-1:0] OPC_END     = 32'd0;
    localparam logic [WORD_W-1:0] OPC_DEV2MEM = 32'd1;
    localparam logic [WORD_W-1:0] OPC_MEM2DEV = 32'd2;

    typedef enum logic [1:0] {
        K_END,
        K_DEV2MEM,
        K_MEM2DEV,
        K_BAD
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LAUNCH,
        S_FETCH,
        S_DECODE,
        S_XFER
    } top_state_e;

    typedef enum logic [2:0] {
        X_IDLE,
        X_DEV_RD,
        X_MEM_WR,
        X_MEM_RD,
        X_DEV_WR
    } xfer_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] opcode;
        logic [WORD_W-1:0] dev;
        logic [WORD_W-1:0] maddr;
        logic [WORD_W-1:0] count;
    } desc_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } mem_cmd_t;

    function automatic op_kind_e classify(input logic [WORD_W-1:0] w);
        op_kind_e k;
        case (w)
            OPC_END:     k = K_END;
            OPC_DEV2MEM: k = K_DEV2MEM;
            OPC_MEM2DEV: k = K_MEM2DEV;
            default:     k = K_BAD;
        endcase
        return k;
    endfunction

    function automatic logic [WORD_W-1:0] next_word(input logic [WORD_W-1:0] a);
        return a + WORD_W'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/iop_desc_fetch.sv
module iop_desc_fetch
    import iop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [WORD_W-1:0] base,
    output mem_cmd_t          cmd,
    input  logic              gnt,
    input  logic [WORD_W-1:0] rdata,
    output logic              done,
    output desc_t             desc
);

    localparam int IDX_BITS = $clog2(DESC_WORDS);

    logic                active;
    logic [IDX_BITS-1:0] idx;
    logic [WORD_W-1:0]   addr;
    logic [WORD_W-1:0]   words [DESC_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            addr   <= '0;
            done   <= 1'b0;
            for (int i = 0; i < DESC_WORDS; i++) words[i] <= '0;
        end else begin
            done <= 1'b0;
            if (!active && go) begin
                active <= 1'b1;
                idx    <= '0;
                addr   <= base;
            end else if (active && gnt) begin
                words[idx] <= rdata;
                if (idx == IDX_BITS'(DESC_WORDS - 1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx  <= idx + 1'b1;
                    addr <= next_word(addr);
                end
            end
        end
    end

    always_comb begin
        cmd.req     = active;
        cmd.we      = 1'b0;
        cmd.addr    = addr;
        cmd.wdata   = '0;
        desc.opcode = words[0];
        desc.dev    = words[1];
        desc.maddr  = words[2];
        desc.count  = words[3];
    end

    // R2
    fetch_quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd.req);

    // R2
    fetch_done_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cmd.req && gnt));

endmodule

// File: rtl/iop_xfer_engine.sv
module iop_xfer_engine
    import iop_pkg::*;
#(
    parameter int DEV_AW = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              to_dev,
    input  logic [DEV_AW-1:0] dev_sel,
    input  logic [WORD_W-1:0] mem_base,
    input  logic [CNT_W-1:0]  words,
    output mem_cmd_t          cmd,
    input  logic              gnt,
    input  logic [WORD_W-1:0] rdata,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [DEV_AW-1:0] dev_addr,
    output logic [WORD_W-1:0] dev_wdata,
    input  logic [WORD_W-1:0] dev_rdata,
    output logic              done
);

    xfer_state_e       st;
    logic [CNT_W-1:0]  left;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] hold;
    logic [DEV_AW-1:0] dsel;
    logic              last;

    assign last = (left == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= X_IDLE;
            left <= '0;
            addr <= '0;
            hold <= '0;
            dsel <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                X_IDLE: begin
                    if (go) begin
                        dsel <= dev_sel;
                        addr <= mem_base;
                        left <= words;
                        if (words == '0) done <= 1'b1;
                        else st <= to_dev ? X_MEM_RD : X_DEV_RD;
                    end
                end
                X_DEV_RD: begin
                    hold <= dev_rdata;
                    st   <= X_MEM_WR;
                end
                X_MEM_WR: begin
                    if (gnt) begin
                        addr <= next_word(addr);
                        left <= left - 1'b1;
                        if (last) begin
                            done <= 1'b1;
                            st   <= X_IDLE;
                        end else begin
                            st <= X_DEV_RD;
                        end
                    end
                end
                X_MEM_RD: begin
                    if (gnt) begin
                        hold <= rdata;
                        addr <= next_word(addr);
                        st   <= X_DEV_WR;
                    end
                end
                X_DEV_WR: begin
                    left <= left - 1'b1;
                    if (last) begin
                        done <= 1'b1;
                        st   <= X_IDLE;
                    end else begin
                        st <= X_MEM_RD;
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd.req   = (st == X_MEM_WR) || (st == X_MEM_RD);
        cmd.we    = (st == X_MEM_WR);
        cmd.addr  = addr;
        cmd.wdata = hold;
        dev_rd    = (st == X_DEV_RD);
        dev_wr    = (st == X_DEV_WR);
        dev_addr  = dsel;
        dev_wdata = hold;
    end

    // R8
    xfer_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.req && !gnt) |=> (cmd.req && $stable(cmd.addr) && $stable(cmd.we)
                               && $stable(cmd.wdata)));

    // R3
    dev_read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        dev_rd |=> (cmd.req && cmd.we));

    // R4
    dev_write_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        dev_wr |-> $past(cmd.req && gnt && !cmd.we));

    // R3
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(dev_rd && dev_wr));

endmodule

// File: rtl/iop_mem_mux.sv
module iop_mem_mux
    import iop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mem_cmd_t          f_cmd,
    input  mem_cmd_t          x_cmd,
    output logic              f_gnt,
    output logic              x_gnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt
);

    mem_cmd_t sel;

    always_comb begin
        sel       = f_cmd.req ? f_cmd : x_cmd;
        mem_req   = sel.req;
        mem_we    = sel.we;
        mem_addr  = sel.addr;
        mem_wdata = sel.wdata;
        f_gnt     = mem_gnt && f_cmd.req;
        x_gnt     = mem_gnt && x_cmd.req && !f_cmd.req;
    end

    // R8
    single_requester_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({f_cmd.req, x_cmd.req}));

    // R8
    aligned_request_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

endmodule

// File: rtl/iop_cmd_proc.sv
module iop_cmd_proc
    import iop_pkg::*;
#(
    parameter int DEV_AW = 8,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       list_base,
    output logic              busy,
    output logic              irq,
    output logic              err_valid,
    output logic [IDX_W-1:0]  err_index,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic [DEV_AW-1:0] dev_addr,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [31:0]       dev_wdata,
    input  logic [31:0]       dev_rdata
);

    top_state_e        st;
    logic [WORD_W-1:0] ptr;
    logic [IDX_W-1:0]  idx;
    mem_cmd_t          f_cmd, x_cmd;
    logic              f_gnt, x_gnt, f_done, x_done;
    logic              f_go, x_go;
    desc_t             desc;
    op_kind_e          kind;
    logic              unused_desc_bits;

    assign kind = classify(desc.opcode);
    assign f_go = (st == S_LAUNCH);
    assign x_go = (st == S_DECODE) && ((kind == K_DEV2MEM) || (kind == K_MEM2DEV));
    assign unused_desc_bits = ^{desc.dev[WORD_W-1:DEV_AW], desc.count[WORD_W-1:CNT_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            ptr       <= '0;
            idx       <= '0;
            busy      <= 1'b0;
            irq       <= 1'b0;
            err_valid <= 1'b0;
            err_index <= '0;
        end else begin
            irq <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        ptr       <= list_base;
                        idx       <= '0;
                        busy      <= 1'b1;
                        err_valid <= 1'b0;
                        err_index <= '0;
                        st        <= S_LAUNCH;
                    end
                end
                S_LAUNCH: st <= S_FETCH;
                S_FETCH:  if (f_done) st <= S_DECODE;
                S_DECODE: begin
                    case (kind)
                        K_END: begin
                            irq  <= 1'b1;
                            busy <= 1'b0;
                            st   <= S_IDLE;
                        end
                        K_BAD: begin
                            irq       <= 1'b1;
                            busy      <= 1'b0;
                            err_valid <= 1'b1;
                            err_index <= idx;
                            st        <= S_IDLE;
                        end
                        default: st <= S_XFER;
                    endcase
                end
                S_XFER: begin
                    if (x_done) begin
                        ptr <= ptr + WORD_W'(DESC_BYTES);
                        idx <= idx + 1'b1;
                        st  <= S_LAUNCH;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    iop_desc_fetch u_fetch (
        .clk   (clk),
        .rst   (rst),
        .go    (f_go),
        .base  (ptr),
        .cmd   (f_cmd),
        .gnt   (f_gnt),
        .rdata (mem_rdata),
        .done  (f_done),
        .desc  (desc)
    );

    iop_xfer_engine #(
        .DEV_AW (DEV_AW),
        .CNT_W  (CNT_W)
    ) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .go        (x_go),
        .to_dev    (kind == K_MEM2DEV),
        .dev_sel   (desc.dev[DEV_AW-1:0]),
        .mem_base  (desc.maddr),
        .words     (desc.count[CNT_W-1:0]),
        .cmd       (x_cmd),
        .gnt       (x_gnt),
        .rdata     (mem_rdata),
        .dev_rd    (dev_rd),
        .dev_wr    (dev_wr),
        .dev_addr  (dev_addr),
        .dev_wdata (dev_wdata),
        .dev_rdata (dev_rdata),
        .done      (x_done)
    );

    iop_mem_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .f_cmd     (f_cmd),
        .x_cmd     (x_cmd),
        .f_gnt     (f_gnt),
        .x_gnt     (x_gnt),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt)
    );

    // R6
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R6
    irq_with_idle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

    // R9
    idle_no_traffic_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !dev_rd && !dev_wr));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(err_valid) && $stable(err_index)));

    // R7
    err_rise_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_valid) |-> irq);

endmodule

// File: tb/test_iop_cmd_proc.sv
module test_iop_cmd_proc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] list_base = '0;
    logic        busy, irq, err_valid;
    logic [7:0]  err_index;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  dev_addr;
    logic        dev_rd, dev_wr;
    logic [31:0] dev_wdata, dev_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    iop_cmd_proc i_iop_cmd_proc (
        .clk(clk), .rst(rst), .start(start), .list_base(list_base),
        .busy(busy), .irq(irq), .err_valid(err_valid), .err_index(err_index),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    // memory, arbiter and device models
    logic [31:0] mem [256];
    logic        poke_en = 1'b0;
    logic [31:0] poke_addr = '0, poke_data = '0;
    logic        stall_mode = 1'b0;
    logic        gnt_allow = 1'b1;
    logic [7:0]  lfsr = 8'hA5;
    logic [15:0] dev_seq = '0;
    logic [31:0] rd_log [128];
    int          rd_n = 0;
    logic [7:0]  dw_addr [64];
    logic [31:0] dw_data [64];
    int          dw_n = 0;

    assign mem_gnt   = mem_req && gnt_allow;
    assign mem_rdata = mem[mem_addr[9:2]];
    assign dev_rdata = {8'hC0, dev_addr, dev_seq};

    always @(posedge clk) begin
        if (poke_en) mem[poke_addr[9:2]] <= poke_data;
        if (mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_req && mem_gnt && !mem_we && rd_n < 128) begin
            rd_log[rd_n] <= mem_addr;
            rd_n <= rd_n + 1;
        end
        if (dev_rd) dev_seq <= dev_seq + 16'd1;
        if (dev_wr && dw_n < 64) begin
            dw_addr[dw_n] <= dev_addr;
            dw_data[dw_n] <= dev_wdata;
            dw_n <= dw_n + 1;
        end
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        gnt_allow <= stall_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
    end

    // handshake monitor for R8, sampled between edges
    logic        p_req = 1'b0, p_gnt = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0, p_wd = '0;
    int          r8_bad = 0;
    always @(negedge clk) begin
        if (!rst && p_req && !p_gnt)
            if (!(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wd))
                r8_bad = r8_bad + 1;
        p_req  = mem_req;
        p_gnt  = mem_gnt;
        p_we   = mem_we;
        p_addr = mem_addr;
        p_wd   = mem_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] op,
                            input logic [31:0] dv, input logic [31:0] ma,
                            input logic [31:0] cnt);
        poke(at, op);
        poke(at + 4, dv);
        poke(at + 8, ma);
        poke(at + 12, cnt);
    endtask

    task automatic pulse_start(input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; list_base = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check({req, " irq seen"}, {31'd0, irq}, 32'd1);
    endtask

    task automatic t_reset;
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 err_valid", {31'd0, err_valid}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 dev strobes", {30'd0, dev_rd, dev_wr}, 32'd0);
    endtask

    task automatic t_two_directions;
        int r0, w0;
        logic [15:0] s0;
        put_desc(32'h100, 32'd1, 32'h12, 32'h200, 32'd3);
        put_desc(32'h110, 32'd2, 32'h34, 32'h300, 32'd2);
        put_desc(32'h120, 32'd0, 32'h0, 32'h0, 32'd0);
        poke(32'h300, 32'h1111_2222);
        poke(32'h304, 32'h3333_4444);
        @(negedge clk);
        r0 = rd_n; w0 = dw_n; s0 = dev_seq;
        pulse_start(32'h100);
        check("R2 busy after start", {31'd0, busy}, 32'd1);
        wait_irq("R6");
        check("R6 busy low with irq", {31'd0, busy}, 32'd0);
        check("R6 no error", {31'd0, err_valid}, 32'd0);
        for (int i = 0; i < 4; i++)
            check("R2 command word address", rd_log[r0 + i], 32'h100 + 32'(4 * i));
        check("R2 next block address", rd_log[r0 + 4], 32'h110);
        check("R4 data read address", rd_log[r0 + 8], 32'h300);
        check("R4 data read address", rd_log[r0 + 9], 32'h304);
        check("R2 third block address", rd_log[r0 + 10], 32'h120);
        for (int i = 0; i < 3; i++)
            check("R3 memory word", mem[(32'h200 >> 2) + i], {8'hC0, 8'h12, s0 + 16'(i)});
        check("R4 device write count", 32'(dw_n - w0), 32'd2);
        check("R5 device address", {24'd0, dw_addr[w0]}, 32'h34);
        check("R4 device word 0", dw_data[w0], 32'h1111_2222);
        check("R4 device word 1", dw_data[w0 + 1], 32'h3333_4444);
        @(negedge clk);
        check("R6 irq one cycle", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_stall_zero_ignore;
        int w0;
        logic [15:0] s0;
        put_desc(32'h040, 32'd1, 32'h05, 32'h280, 32'd4);
        put_desc(32'h050, 32'd2, 32'h06, 32'h300, 32'h0001_0000);
        put_desc(32'h060, 32'd0, 32'h0, 32'h0, 32'd0);
        @(negedge clk);
        w0 = dw_n; s0 = dev_seq;
        stall_mode = 1'b1;
        pulse_start(32'h040);
        repeat (3) @(negedge clk);
        pulse_start(32'h0C0);
        wait_irq("R9");
        check("R9 second start ignored", {31'd0, err_valid}, 32'd0);
        for (int i = 0; i < 4; i++)
            check("R8 stalled write data", mem[(32'h280 >> 2) + i], {8'hC0, 8'h05, s0 + 16'(i)});
        check("R5 zero count no device write", 32'(dw_n - w0), 32'd0);
        check("R8 request held until grant", 32'(r8_bad), 32'd0);
        stall_mode = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_bad_opcode;
        int w0;
        @(negedge clk);
        w0 = dw_n;
        pulse_start(32'h0C0);
        wait_irq("R7");
        check("R7 err_valid", {31'd0, err_valid}, 32'd1);
        check("R7 err_index", {24'd0, err_index}, 32'd1);
        check("R7 busy low", {31'd0, busy}, 32'd0);
        check("R4 word moved before error", dw_data[w0], 32'hBEEF_0001);
        @(negedge clk);
        check("R6 irq one cycle on error", {31'd0, irq}, 32'd0);
        repeat (10) @(negedge clk);
        check("R10 err_valid held", {31'd0, err_valid}, 32'd1);
        check("R10 err_index held", {24'd0, err_index}, 32'd1);
        check("R9 idle no request", {31'd0, mem_req}, 32'd0);
        put_desc(32'h3F0, 32'd0, 32'h0, 32'h0, 32'd0);
        pulse_start(32'h3F0);
        check("R10 cleared by start", {31'd0, err_valid}, 32'd0);
        check("R10 index cleared", {24'd0, err_index}, 32'd0);
        wait_irq("R6");
        check("R6 end-only list", {31'd0, err_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        put_desc(32'h0C0, 32'd2, 32'h07, 32'h308, 32'd1);
        put_desc(32'h0D0, 32'd5, 32'h0, 32'h0, 32'd0);
        poke(32'h308, 32'hBEEF_0001);
        t_two_directions();
        t_stall_zero_ignore();
        t_bad_opcode();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule